// File: doc/BRIEF.md
# Serial LED Driver Reload Sequencer

This block refreshes a bank of four serial-input, eight-digit LED driver devices. Such drivers cannot take a change to a single digit, so every refresh writes the whole bank. The drivers are arranged as two pairs. A single write goes to all four drivers at once and sets their operating mode. Sixteen data writes follow: the first eight go to pair 0 and the next eight go to pair 1. The data for each write is read from an external digit store, which the block addresses directly.

A refresh is requested on an input that is asynchronous to the block clock. The request may be as short as one clock. It passes through a two-stage synchronizer, and its rising edge is held as a pending flag. The sequence then advances only on a slow step enable, which runs independently of the request. Each write takes two step periods. In the first period the bus data is set up with all strobes high. In the second period the selected active-low strobes are held low. A request that arrives while a reload is running is remembered and starts one more reload once the current one has finished.

The sequence state is five bits wide. It starts at 11110 and moves to 11111, where the mode word is written. It then counts 00000 to 01111 for the sixteen data writes, and the carry out of the low four bits lands it in 10000. It rests in 10000 until the next request. Because the store address rises from 0 to 15, the drivers receive their digits from the highest enable index downward (enable index = 15 - address).

Top module: `seqdrv_loader`

## Requirements
- R1: After reset, wr_n is 2'b11, mode_sel is 0, store_addr is 0 and bus_data is 0, and no strobe goes low until a request is made.
- R2: One request produces exactly 17 write strobes, counted as falling edges of any wr_n bit. After that, no strobe goes low until the next request.
- R3: The first strobe of a reload drives both wr_n bits low together, with mode_sel = 1 and bus_data equal to the MODE_WORD parameter.
- R4: Strobes 2 to 9 drive only wr_n[0] low (wr_n = 2'b10), with store_addr = 0 to 7 in ascending order. Strobes 10 to 17 drive only wr_n[1] low (wr_n = 2'b01), with store_addr = 8 to 15. In every data strobe, mode_sel = 0 and bus_data equals the digit store word at store_addr. Ascending addresses write the digits from enable index 15 down to 0.
- R5: Each strobe stays low for exactly one step period. Between strobes, wr_n is 2'b11 for at least one step period. bus_data does not change while a strobe is low.
- R6: A request pulse only one clock wide is captured and starts a full reload.
- R7: Requests that arrive during a reload start exactly one further reload after the current one. Several such requests merge into that single extra reload.
- R8: The sequence state changes only on clocks where step_en is high. With step_en held low, a pending request produces no strobe.
- R9: The state moves 11110 to 11111 to 00000, counts up through 01111 to 10000, and holds at 10000 until a pending request moves it to 11110.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_req | input | 1 | Asynchronous refresh request; the rising edge counts |
| step_en | input | 1 | Slow step enable, one clock wide |
| store_data | input | DATA_W | Word read from the digit store at store_addr |
| store_addr | output | 4 | Digit store address, equal to the low four state bits |
| bus_data | output | DATA_W | Word presented to the drivers |
| mode_sel | output | 1 | 1 while the mode word is on bus_data |
| wr_n | output | 2 | Active-low write strobe for driver pair 0 (bit 0) and pair 1 (bit 1) |

## Verification
The assertions check the state walk on every cycle: the entry to 11110, the step from the mode state into data and from the last data state into stop, and holding at stop. They also check that nothing moves without step_en, that a synchronized edge always leaves a pending request, that an all-low strobe only happens with mode_sel, and that bus_data stays stable under a strobe. Only the bench scenarios can show the things that span a whole reload: exactly 17 strobes per request, their pair and address order, the word on the bus compared with random store contents, the strobe and gap lengths, one-clock request pulses, and merging of repeated requests.

// File: rtl/seqdrv_pkg.sv
package seqdrv_pkg;
  localparam int ST_W   = 5;
  localparam int ADDR_W = ST_W - 1;

  typedef logic [ST_W-1:0] st_t;

  localparam st_t ST_START = 5'b11110;
  localparam st_t ST_MODE  = 5'b11111;
  localparam st_t ST_STOP  = 5'b10000;

  // advance: the carry out of the low nibble sets the fifth bit
  function automatic st_t st_next(st_t s);
    return s + st_t'(1);
  endfunction

  function automatic logic st_is_data(st_t s);
    return !s[ST_W-1];
  endfunction

  // driver pair served by a data state
  function automatic logic st_pair(st_t s);
    return s[ADDR_W-1];
  endfunction

  // digit enable index written by a given store address
  function automatic logic [ADDR_W-1:0] enable_index(logic [ADDR_W-1:0] a);
    return {ADDR_W{1'b1}} - a;
  endfunction
endpackage

// File: rtl/seqdrv_req_sync.sv
module seqdrv_req_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_async,
  output logic req_rise
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], req_async};
      last_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign req_rise = sync_q[SYNC_STAGES-1] && !last_q;
endmodule

// File: rtl/seqdrv_counter.sv
module seqdrv_counter
  import seqdrv_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic step_en,
  input  logic req_rise,
  output st_t  st,
  output logic phase,
  output logic pending,
  output logic start_evt
);
  logic active;

  assign active    = (st != ST_STOP);
  assign start_evt = step_en && !active && pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_STOP;
      phase   <= 1'b0;
      pending <= 1'b0;
    end else begin
      pending <= (pending && !start_evt) || req_rise;
      if (start_evt) begin
        st    <= ST_START;
        phase <= 1'b0;
      end else if (step_en && active) begin
        phase <= !phase;
        if (phase) st <= st_next(st);
      end
    end
  end

  a_r9_start_enters: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (st == ST_START) && !phase);
  a_r9_mode_to_data: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_MODE && phase && step_en) |=> (st == 5'b00000));
  a_r9_last_to_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 5'b01111 && phase && step_en) |=> (st == ST_STOP));
  a_r9_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_STOP && !start_evt) |=> (st == ST_STOP));
  a_r8_no_step_no_move: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(st) && $stable(phase));
  a_r7_edge_kept: assert property (@(posedge clk) disable iff (!rst_n)
    req_rise |=> pending);
endmodule

// File: rtl/seqdrv_outmap.sv
module seqdrv_outmap
  import seqdrv_pkg::*;
#(
  parameter int              DATA_W    = 8,
  parameter logic [DATA_W-1:0] MODE_WORD = 8'hA5
) (
  input  st_t               st,
  input  logic              phase,
  input  logic [DATA_W-1:0] store_data,
  output logic [ADDR_W-1:0] store_addr,
  output logic [DATA_W-1:0] bus_data,
  output logic              mode_sel,
  output logic [1:0]        wr_n
);
  assign store_addr = st[ADDR_W-1:0];
  assign mode_sel   = (st == ST_MODE);

  always_comb begin
    if (mode_sel)            bus_data = MODE_WORD;
    else if (st_is_data(st)) bus_data = store_data;
    else                     bus_data = '0;
  end

  for (genvar p = 0; p < 2; p++) begin : g_pair
    logic hit;
    assign hit     = mode_sel || (st_is_data(st) && (st_pair(st) == 1'(p)));
    assign wr_n[p] = !(phase && hit);
  end
endmodule

// File: rtl/seqdrv_loader.sv
module seqdrv_loader
  import seqdrv_pkg::*;
#(
  parameter int                DATA_W    = 8,
  parameter logic [DATA_W-1:0] MODE_WORD = 8'hA5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_req,
  input  logic              step_en,
  input  logic [DATA_W-1:0] store_data,
  output logic [3:0]        store_addr,
  output logic [DATA_W-1:0] bus_data,
  output logic              mode_sel,
  output logic [1:0]        wr_n
);
  logic req_rise;
  logic phase;
  logic pending;
  logic start_evt;
  st_t  st;

  seqdrv_req_sync #(.SYNC_STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .req_async(upd_req), .req_rise(req_rise));

  seqdrv_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .req_rise(req_rise),
    .st(st), .phase(phase), .pending(pending), .start_evt(start_evt));

  seqdrv_outmap #(.DATA_W(DATA_W), .MODE_WORD(MODE_WORD)) u_map (
    .st(st), .phase(phase), .store_data(store_data),
    .store_addr(store_addr), .bus_data(bus_data),
    .mode_sel(mode_sel), .wr_n(wr_n));

  a_r3_all_low_is_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_n == 2'b00) |-> mode_sel);
  a_r5_bus_held: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_n != 2'b11 && $past(wr_n) != 2'b11) |-> $stable(bus_data));
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_STOP) |-> (wr_n == 2'b11) && !mode_sel);
endmodule

// File: tb/seqdrv_loader_bench.sv
module seqdrv_loader_bench;
  localparam int         STEP_PER = 10;
  localparam int         DATA_W   = 8;
  localparam logic [7:0] MODE_W   = 8'hA5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       upd_req = 1'b0;
  logic       step_en = 1'b0;
  logic       gate = 1'b1;
  logic [7:0] mem [16];
  logic [7:0] store_data;
  logic [3:0] store_addr;
  logic [7:0] bus_data;
  logic       mode_sel;
  logic [1:0] wr_n;

  int n_chk = 0, n_fail = 0, cyc = 0, step_cnt = 0;
  int ev_idx = 0, low_run = 0, high_run = 1000;
  logic [7:0] held_bus;
  logic [1:0] prev_wr = 2'b11;

  always #5 clk = ~clk;

  assign store_data = mem[store_addr];

  seqdrv_loader #(.DATA_W(DATA_W), .MODE_WORD(MODE_W)) u_seqdrv_loader (
    .clk(clk), .rst_n(rst_n), .upd_req(upd_req), .step_en(step_en),
    .store_data(store_data), .store_addr(store_addr), .bus_data(bus_data),
    .mode_sel(mode_sel), .wr_n(wr_n));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // expected strobe pattern for event k within a reload
  function automatic logic [1:0] exp_wr(int k);
    if (k == 0) return 2'b00;
    return (k <= 8) ? 2'b10 : 2'b01;
  endfunction

  function automatic int exp_addr(int k);
    return k - 1;
  endfunction

  // step enable generator, updated away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (step_cnt == STEP_PER - 1) begin
      step_cnt = 0;
      step_en  = gate;
    end else begin
      step_cnt++;
      step_en = 1'b0;
    end
    if (cyc > 190000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
      finish_run();
    end
  end

  // strobe monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_wr == 2'b11 && wr_n != 2'b11) begin
        int k;
        k = ev_idx % 17;
        check(high_run >= STEP_PER, "R5 gap", high_run, STEP_PER);
        check(wr_n == exp_wr(k), k == 0 ? "R3 wr_n" : "R4 wr_n", wr_n, exp_wr(k));
        if (k == 0) begin
          check(mode_sel == 1'b1, "R3 mode_sel", mode_sel, 1);
          check(bus_data == MODE_W, "R3 bus", bus_data, MODE_W);
        end else begin
          check(mode_sel == 1'b0, "R4 mode_sel", mode_sel, 0);
          check(store_addr == exp_addr(k), "R4 addr", store_addr, exp_addr(k));
          check(bus_data == mem[exp_addr(k)], "R4 bus", bus_data, mem[exp_addr(k)]);
        end
        held_bus = bus_data;
        ev_idx++;
        low_run = 1;
      end else if (wr_n != 2'b11) begin
        low_run++;
        if (bus_data != held_bus)
          check(1'b0, "R5 bus stable", bus_data, held_bus);
      end else if (prev_wr != 2'b11) begin
        check(low_run == STEP_PER, "R5 width", low_run, STEP_PER);
        high_run = 1;
      end else begin
        high_run++;
      end
      prev_wr = wr_n;
    end
  end

  task automatic pulse_req(input int width);
    @(negedge clk);
    upd_req = 1'b1;
    repeat (width) @(negedge clk);
    upd_req = 1'b0;
  endtask

  task automatic wait_events(input int target, input string req);
    for (int i = 0; i < 4000 && ev_idx < target; i++) @(negedge clk);
    repeat (40 * STEP_PER) @(negedge clk);
    check(ev_idx == target, req, ev_idx, target);
  endtask

  task automatic fill_mem();
    for (int i = 0; i < 16; i++) mem[i] = 8'($urandom);
  endtask

  initial begin
    int base;
    void'($urandom(32'd7421));
    fill_mem();
    repeat (4) @(negedge clk);
    check(wr_n == 2'b11, "R1 wr_n in reset", wr_n, 3);
    rst_n = 1'b1;
    repeat (3 * STEP_PER) @(negedge clk);
    check(wr_n == 2'b11, "R1 wr_n", wr_n, 3);
    check(mode_sel == 1'b0, "R1 mode_sel", mode_sel, 0);
    check(store_addr == 4'd0, "R1 addr", store_addr, 0);
    check(bus_data == 8'd0, "R1 bus", bus_data, 0);
    check(ev_idx == 0, "R1 no strobe", ev_idx, 0);

    // single reload from a one-clock request
    pulse_req(1);
    wait_events(17, "R2 R6 single reload count");

    // step enable held off: request must wait
    gate = 1'b0;
    pulse_req(3);
    repeat (20 * STEP_PER) @(negedge clk);
    check(ev_idx == 17, "R8 no strobe without step_en", ev_idx, 17);
    gate = 1'b1;
    wait_events(34, "R8 resumes after step_en");

    // one request during a reload gives one extra reload
    pulse_req(1);
    for (int i = 0; i < 4000 && ev_idx < 37; i++) @(negedge clk);
    pulse_req(2);
    wait_events(68, "R7 one extra reload");

    // several requests during a reload merge
    pulse_req(1);
    for (int i = 0; i < 4000 && ev_idx < 70; i++) @(negedge clk);
    pulse_req(1);
    repeat (3 * STEP_PER) @(negedge clk);
    pulse_req(1);
    repeat (5 * STEP_PER) @(negedge clk);
    pulse_req(4);
    wait_events(102, "R7 merged requests");

    // random contents and random request timing
    for (int it = 0; it < 8; it++) begin
      fill_mem();
      repeat (1 + ($urandom % 50)) @(negedge clk);
      base = ev_idx;
      pulse_req(1 + ($urandom % 3));
      wait_events(base + 17, "R2 random reload count");
    end

    repeat (10 * STEP_PER) @(negedge clk);
    check(wr_n == 2'b11, "R2 idle after reloads", wr_n, 3);
    finish_run();
  end
endmodule